// File: doc/BRIEF.md
# NAND Asynchronous Bus Timing Sequencer

This block drives the pins of an asynchronous NAND flash bus: one chip-enable line per chip, the command-latch and address-latch enables, the write and read strobes, the outbound data byte with its output enable, and a synchronised ready/busy input. It takes one transfer descriptor at a time over a valid/ready handshake. A descriptor names a mode (write, read or wait-for-ready), a latch target (data, command latch or address latch), an increment flag, a chip select, a keep-selected flag and a byte count. Write bytes come from a streaming source. Read bytes leave on a one-cycle valid pulse.

Three configuration inputs shape every strobe. The address-setup count sets a lead-in with the chip enabled before the first strobe. The data-setup count sets the strobe low time. The data-hold count sets the strobe high time. A byte therefore takes setup plus hold clocks. A wait-for-ready descriptor drives no strobes. It ends when the synchronised ready/busy line is high, or it ends with an error when a timeout of the busy field times 4096 clocks runs out. A timeout also sets a sticky error flag.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, every `nand_ce_n` bit is 1, both strobes are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `done`, `done_err` and `err_sticky` are 0. `cmd_ready` is 1 only while idle, and a descriptor is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1.
- R2: Let A, S and H be `cfg_addr_setup`, `cfg_data_setup` and `cfg_data_hold`, each with 0 read as 1. A read or write of N>0 bytes has an A-cycle lead-in with the strobes high. Then each byte holds its strobe low for S cycles and high for H cycles. `done` is 1 in the cycle that begins A+N·(S+H) edges after the accepting edge, provided write data never stalls.
- R3: `cmd_mode`=0 is write. Only `nand_we_n` strobes. Each byte takes one word from the write stream (a word moves on an edge with `wr_valid` and `wr_ready` both 1). That word is on `nand_dq_out` with `nand_dq_oe`=1 for the whole strobe-low and hold time of its byte.
- R4: `cmd_mode`=1 is read. Only `nand_re_n` strobes. `nand_dq_in` is sampled on the edge where `nand_re_n` returns high. In the following cycle `rd_valid` is 1 for one cycle with that byte on `rd_data`.
- R5: `cmd_target` selects the latch lines during lead-in, strobe and hold. A value of 0 or 3 selects neither line. A value of 1 selects `nand_cle`. A value of 2 selects `nand_ale`. With 1 and `cmd_incr`=1, the first byte uses `nand_cle` and every later byte uses `nand_ale`.
- R6: `nand_ce_n[cmd_cs]` is 0 from the cycle after acceptance until `done`, and at most one chip enable is ever low. In the `done` cycle the enable stays low if `cmd_lock` was 1 and is high otherwise.
- R7: A read or write with `cmd_count`=0 produces no strobe, and `done` is 1 in the cycle right after the accepting edge.
- R8: `cmd_mode` 2 or 3 is wait-for-ready and produces no strobe. `nand_rb` passes through two flops. A wait that sees the synchronised line high finishes with `done`=1 and `done_err`=0 one cycle later. A rise at a falling clock edge therefore finishes the wait 3 cycles later.
- R9: With busy field F, a wait that never sees ready completes with `done`=1 and `done_err`=1 in the cycle F·4096 after acceptance. When F=0 this happens in cycle 1.
- R10: When the synchronised ready is first seen high in the last cycle before the timeout, ready wins and `done_err` is 0.
- R11: `err_sticky` becomes 1 with the first timeout and stays 1 until reset, through later successful descriptors.
- R12: When a write byte is due and `wr_valid` is 0, the bus holds with `nand_we_n` high. The transfer resumes one cycle after the word arrives, and completion moves later by the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_setup | input | T_W | Lead-in cycles before the first strobe (0 read as 1) |
| cfg_data_setup | input | T_W | Strobe-low cycles per byte (0 read as 1) |
| cfg_data_hold | input | T_W | Strobe-high cycles per byte (0 read as 1) |
| cfg_busy_to | input | BT_W | Busy timeout in units of 4096 clocks |
| cmd_valid | input | 1 | Descriptor valid |
| cmd_ready | output | 1 | Sequencer idle and ready for a descriptor |
| cmd_mode | input | 2 | 0 write, 1 read, 2 or 3 wait-for-ready |
| cmd_target | input | 2 | 0/3 data, 1 command latch, 2 address latch |
| cmd_incr | input | 1 | Command latch for the first byte, address latch after it |
| cmd_cs | input | CS_W | Chip to enable |
| cmd_lock | input | 1 | Keep the chip enabled after completion |
| cmd_count | input | CNT_W | Bytes to move |
| wr_valid | input | 1 | Write stream word valid |
| wr_ready | output | 1 | Write stream word taken on this edge if valid |
| wr_data | input | 8 | Write stream word |
| rd_valid | output | 1 | One-cycle pulse with a captured read byte |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-cycle descriptor completion pulse |
| done_err | output | 1 | Completion was a timeout |
| err_sticky | output | 1 | A timeout has occurred since reset |
| nand_ce_n | output | NCS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Outbound data byte |
| nand_dq_oe | output | 1 | Outbound data enable |
| nand_dq_in | input | 8 | Inbound data byte |
| nand_rb | input | 1 | Asynchronous ready (1) / busy (0) |

## Verification
Two events can land in the same cycle: the synchronised ready line being seen high, and the busy timer running out. With a busy field of 1, the bench raises `nand_rb` at the falling edge of cycle 4093 after acceptance. This puts the synchronised level in cycle 4095, the last counted cycle. The bench then expects a clean completion in cycle 4096. The same wait with the rise one cycle later must instead complete in cycle 4096 with `done_err` and `err_sticky` set. That brackets the priority from both sides.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // descriptor mode encodings (bit 1 set means wait-for-ready)
  localparam logic [1:0] MODE_WRITE = 2'd0;
  localparam logic [1:0] MODE_READ  = 2'd1;

  // latch target encodings (0 and 3 both mean plain data)
  localparam logic [1:0] TGT_CMD  = 2'd1;
  localparam logic [1:0] TGT_ADDR = 2'd2;

  // busy timeout field is scaled by 2**BUSY_SCALE_SH clocks
  localparam int BUSY_SCALE_SH = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nand_seq_phase_ctr.sv
module nand_seq_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_len,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? (load_len - W'(1)) : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/nand_seq_busy_tmr.sv
module nand_seq_busy_tmr #(
  parameter int FW = 4,
  parameter int SH = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [FW-1:0] field,
  output logic          expire
);
  localparam int CW = FW + SH + 1;

  logic [CW-1:0] cnt_q, cnt_inc, limit;

  assign cnt_inc = cnt_q + CW'(1);
  assign limit   = {1'b0, field, {SH{1'b0}}};
  // expires in the cycle whose count is limit-1 (or at once when limit is 0)
  assign expire  = (cnt_inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int NCS   = 2,
  parameter int CNT_W = 8,
  parameter int T_W   = 4,
  parameter int BT_W  = 4,
  localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [T_W-1:0]   cfg_addr_setup,
  input  logic [T_W-1:0]   cfg_data_setup,
  input  logic [T_W-1:0]   cfg_data_hold,
  input  logic [BT_W-1:0]  cfg_busy_to,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_mode,
  input  logic [1:0]       cmd_target,
  input  logic             cmd_incr,
  input  logic [CS_W-1:0]  cmd_cs,
  input  logic             cmd_lock,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             done_err,
  output logic             err_sticky,
  output logic [NCS-1:0]   nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb
);

  function automatic logic [T_W-1:0] at_least_one(input logic [T_W-1:0] v);
    return (v == '0) ? T_W'(1) : v;
  endfunction

  seq_state_e       st_q, st_d;
  logic [1:0]       mode_q, tgt_q;
  logic             incr_q, lock_q, ce_on_q;
  logic [CS_W-1:0]  cs_q;
  logic [CNT_W-1:0] total_q, rem_q, rem_d;
  logic [7:0]       dq_q, rd_q;
  logic             rdv_q, done_q, derr_q, sticky_q;

  logic             accept, rb_s, ph_last, tmo;
  logic             ld, fin, fin_err, cap, wr_pop, adv_ok;
  logic             is_wr, is_rd, in_bus, first_byte;
  logic [T_W-1:0]   ld_len;

  nand_seq_sync #(.STAGES(2)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d_async(nand_rb), .q_sync(rb_s)
  );

  nand_seq_phase_ctr #(.W(T_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_len(ld_len), .last(ph_last)
  );

  nand_seq_busy_tmr #(.FW(BT_W), .SH(BUSY_SCALE_SH)) u_busy (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(st_q == ST_WAIT),
    .field(cfg_busy_to), .expire(tmo)
  );

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign is_wr     = (mode_q == MODE_WRITE);
  assign is_rd     = (mode_q == MODE_READ);

  // a write byte is due at the end of lead-in or of a non-final hold
  assign wr_ready  = is_wr && ph_last &&
                     ((st_q == ST_LEAD) ||
                      ((st_q == ST_HIGH) && (rem_q != CNT_W'(1))));
  assign wr_pop    = wr_ready && wr_valid;
  assign adv_ok    = !is_wr || wr_valid;

  // next-state process
  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    ld      = 1'b0;
    ld_len  = T_W'(1);
    fin     = 1'b0;
    fin_err = 1'b0;
    cap     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_mode[1]) begin
            st_d = ST_WAIT;
          end else if (cmd_count == '0) begin
            fin = 1'b1;
          end else begin
            st_d   = ST_LEAD;
            ld     = 1'b1;
            ld_len = at_least_one(cfg_addr_setup);
          end
        end
      end
      ST_LEAD: begin
        if (ph_last && adv_ok) begin
          st_d   = ST_LOW;
          ld     = 1'b1;
          ld_len = at_least_one(cfg_data_setup);
        end
      end
      ST_LOW: begin
        if (ph_last) begin
          st_d   = ST_HIGH;
          ld     = 1'b1;
          ld_len = at_least_one(cfg_data_hold);
          cap    = is_rd;
        end
      end
      ST_HIGH: begin
        if (ph_last) begin
          if (rem_q == CNT_W'(1)) begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end else if (adv_ok) begin
            st_d   = ST_LOW;
            rem_d  = rem_q - CNT_W'(1);
            ld     = 1'b1;
            ld_len = at_least_one(cfg_data_setup);
          end
        end
      end
      ST_WAIT: begin
        if (rb_s) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end else if (tmo) begin
          st_d    = ST_IDLE;
          fin     = 1'b1;
          fin_err = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mode_q   <= '0;
      tgt_q    <= '0;
      incr_q   <= 1'b0;
      lock_q   <= 1'b0;
      cs_q     <= '0;
      total_q  <= '0;
      rem_q    <= '0;
      ce_on_q  <= 1'b0;
      dq_q     <= '0;
      rd_q     <= '0;
      rdv_q    <= 1'b0;
      done_q   <= 1'b0;
      derr_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rdv_q  <= cap;
      done_q <= fin;
      derr_q <= fin_err;
      if (accept) begin
        mode_q  <= cmd_mode;
        tgt_q   <= cmd_target;
        incr_q  <= cmd_incr;
        lock_q  <= cmd_lock;
        cs_q    <= cmd_cs;
        total_q <= cmd_count;
        rem_q   <= cmd_count;
        ce_on_q <= fin ? cmd_lock : 1'b1;
      end else begin
        rem_q <= rem_d;
        if (fin) ce_on_q <= lock_q;
      end
      if (wr_pop)  dq_q     <= wr_data;
      if (cap)     rd_q     <= nand_dq_in;
      if (fin_err) sticky_q <= 1'b1;
    end
  end

  // pin decode
  assign in_bus     = (st_q == ST_LEAD) || (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign first_byte = (rem_q == total_q);

  assign nand_cle    = in_bus && (tgt_q == TGT_CMD) && (!incr_q || first_byte);
  assign nand_ale    = in_bus && ((tgt_q == TGT_ADDR) ||
                                  ((tgt_q == TGT_CMD) && incr_q && !first_byte));
  assign nand_we_n   = !((st_q == ST_LOW) && is_wr);
  assign nand_re_n   = !((st_q == ST_LOW) && is_rd);
  assign nand_dq_oe  = is_wr && ((st_q == ST_LOW) || (st_q == ST_HIGH));
  assign nand_dq_out = dq_q;

  for (genvar gi = 0; gi < NCS; gi++) begin : g_ce
    assign nand_ce_n[gi] = !(ce_on_q && (cs_q == CS_W'(gi)));
  end

  assign rd_valid   = rdv_q;
  assign rd_data    = rd_q;
  assign done       = done_q;
  assign done_err   = derr_q;
  assign err_sticky = sticky_q;

endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_ready,
  input logic           nand_we_n,
  input logic           nand_re_n,
  input logic           nand_cle,
  input logic           nand_ale,
  input logic [NCS-1:0] nand_ce_n,
  input logic           nand_dq_oe,
  input logic           done,
  input logic           done_err,
  input logic           err_sticky,
  input logic           rd_valid
);

  // R3 / R4: never both strobes low
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R5: one latch line at a time
  assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R1: no new descriptor while a strobe is active
  assert_busy_while_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !cmd_ready);

  // R6: at most one chip enable low
  assert_ce_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  // R6: a strobe only with some chip enabled
  assert_strobe_has_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));

  // R3: write strobe low only while data is driven
  assert_we_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  // R4: read byte reported right when the read strobe returns high
  assert_capture_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(nand_re_n));

  // R9: error status only alongside completion
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  // R11: sticky error never clears
  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

endmodule

bind nand_bus_seq nand_bus_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
  .nand_dq_oe(nand_dq_oe), .done(done), .done_err(done_err),
  .err_sticky(err_sticky), .rd_valid(rd_valid)
);

// File: tb/nand_bus_seq_tb_top.sv
`timescale 1ns/1ps
module nand_bus_seq_tb_top;

  localparam int NCS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_addr_setup, cfg_data_setup, cfg_data_hold, cfg_busy_to;
  logic       cmd_valid, cmd_ready, cmd_incr, cmd_lock;
  logic [1:0] cmd_mode, cmd_target;
  logic [0:0] cmd_cs;
  logic [7:0] cmd_count;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_data, rd_data, nand_dq_out, nand_dq_in;
  logic       rd_valid, done, done_err, err_sticky;
  logic [1:0] nand_ce_n;
  logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;
  logic [7:0] wexp;

  always #4 clk = ~clk;

  nand_bus_seq #(.NCS(NCS), .CNT_W(8), .T_W(4), .BT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_setup(cfg_addr_setup), .cfg_data_setup(cfg_data_setup),
    .cfg_data_hold(cfg_data_hold), .cfg_busy_to(cfg_busy_to),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .cmd_target(cmd_target), .cmd_incr(cmd_incr), .cmd_cs(cmd_cs),
    .cmd_lock(cmd_lock), .cmd_count(cmd_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .done_err(done_err), .err_sticky(err_sticky),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc_total, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // mode 0 write, 1 read; target 0/3 data, 1 cmd latch, 2 addr latch
  task automatic run_cmd(input int mode, input int tgt, input int incr, input int cs,
                         input int lock, input int cnt, input int a, input int s,
                         input int h, input int stall);
    int ap = nz(a);
    int sp = nz(s);
    int hp = nz(h);
    int exp_lat = (cnt == 0) ? 0 : ap + cnt * (sp + hp) + stall;
    int c = 0;
    int nstb = 0, nlow = 0, nother = 0, ce_bad = 0, rd_got = 0, rd_drv = 0;
    bit prev_stb = 1'b1;
    bit pend = 1'b0;
    logic [1:0] ce_exp = ~(2'(1) << cs);
    bit stb, ecle, eale;
    @(negedge clk);
    cfg_addr_setup = 4'(a); cfg_data_setup = 4'(s); cfg_data_hold = 4'(h);
    cmd_mode = 2'(mode); cmd_target = 2'(tgt); cmd_incr = incr[0];
    cmd_cs = cs[0:0]; cmd_lock = lock[0]; cmd_count = 8'(cnt);
    cmd_valid = 1'b1; wr_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    forever begin
      if (pend) wr_data = wr_data + 8'd1;
      if (c == stall) wr_valid = 1'b1;
      pend = wr_ready && wr_valid;
      if (done) break;
      if (nand_ce_n != ce_exp) ce_bad++;
      stb = (mode == 0) ? !nand_we_n : !nand_re_n;
      if ((mode == 0) ? !nand_re_n : !nand_we_n) nother++;
      if (stb) nlow++;
      if (stb && prev_stb) begin
        ecle = (tgt == 1) && (incr == 0 || nstb == 0);
        eale = (tgt == 2) || (tgt == 1 && incr == 1 && nstb > 0);
        chk(nand_cle == ecle, "R5 cle level", nand_cle, ecle);
        chk(nand_ale == eale, "R5 ale level", nand_ale, eale);
        if (mode == 0) begin
          chk(nand_dq_out == wexp && nand_dq_oe, "R3 write byte", nand_dq_out, wexp);
          wexp = wexp + 8'd1;
        end else begin
          nand_dq_in = 8'hA0 + 8'(rd_drv);
          rd_drv++;
        end
        nstb++;
      end
      if (rd_valid) begin
        chk(rd_data == 8'hA0 + 8'(rd_got), "R4 read byte", rd_data, 8'hA0 + rd_got);
        rd_got++;
      end
      prev_stb = !stb;
      @(negedge clk);
      c++;
      if (c > 9000) begin
        chk(1'b0, "R2 transfer hung", c, exp_lat);
        break;
      end
    end
    if (cnt == 0)
      chk(c == 0 && nstb == 0, "R7 zero count", c, 0);
    else if (stall > 0)
      chk(c == exp_lat, "R12 stalled latency", c, exp_lat);
    else
      chk(c == exp_lat, "R2 latency", c, exp_lat);
    chk(nstb == cnt, "R2 strobe count", nstb, cnt);
    chk(nlow == cnt * sp, "R2 strobe low cycles", nlow, cnt * sp);
    chk(nother == 0, "R3 other strobe idle", nother, 0);
    if (mode == 1) chk(rd_got == cnt, "R4 read count", rd_got, cnt);
    chk(ce_bad == 0, "R6 ce during transfer", ce_bad, 0);
    chk(nand_ce_n == (lock != 0 ? ce_exp : 2'b11), "R6 ce after done",
        nand_ce_n, lock != 0 ? ce_exp : 3);
    chk(!done_err, "R2 no error status", done_err, 0);
  endtask

  task automatic run_wait(input int mode, input int field, input int raise_at,
                          input int exp_lat, input bit exp_err, input string tag);
    int c = 0;
    int nstb = 0;
    @(negedge clk);
    cfg_busy_to = 4'(field);
    cmd_mode = 2'(mode); cmd_target = 2'd0; cmd_incr = 1'b0;
    cmd_cs = 1'b0; cmd_lock = 1'b0; cmd_count = 8'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    forever begin
      if (c == raise_at) nand_rb = 1'b1;
      if (done) break;
      if (!nand_we_n || !nand_re_n) nstb++;
      @(negedge clk);
      c++;
      if (c > 9000) break;
    end
    chk(c == exp_lat, {tag, " wait latency"}, c, exp_lat);
    chk(done_err == exp_err, {tag, " error status"}, done_err, exp_err);
    chk(nstb == 0, "R8 no strobes in wait", nstb, 0);
  endtask

  task automatic rb_settle(input bit v);
    nand_rb = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_addr_setup = 4'd1; cfg_data_setup = 4'd1; cfg_data_hold = 4'd1; cfg_busy_to = 4'd1;
    cmd_valid = 1'b0; cmd_mode = 2'd0; cmd_target = 2'd0; cmd_incr = 1'b0;
    cmd_cs = 1'b0; cmd_lock = 1'b0; cmd_count = 8'd0;
    wr_valid = 1'b1; wr_data = 8'h30; wexp = 8'h30;
    nand_dq_in = 8'h00; nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(nand_ce_n == 2'b11, "R1 ce idle", nand_ce_n, 3);
    chk(nand_we_n && nand_re_n, "R1 strobes idle", {nand_we_n, nand_re_n}, 3);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latch/oe idle",
        {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(!done && !done_err && !err_sticky, "R1 status idle",
        {done, done_err, err_sticky}, 0);

    // R2/R3 write timing sweep
    for (int a = 0; a <= 2; a++)
      for (int s = 0; s <= 3; s++)
        for (int h = 1; h <= 3; h++)
          for (int n = 1; n <= 3; n += 2)
            run_cmd(0, 0, 0, 0, 0, n, a, s, h, 0);

    // R4 read sweep
    for (int s = 0; s <= 3; s++)
      for (int h = 1; h <= 2; h++)
        for (int n = 1; n <= 4; n += 3)
          run_cmd(1, 0, 0, 1, 0, n, 1, s, h, 0);

    // R5 latch targets with and without increment
    for (int t = 0; t <= 3; t++)
      for (int inc = 0; inc <= 1; inc++)
        run_cmd(0, t, inc, 0, 0, 3, 1, 1, 1, 0);

    // R6 chip select lock, switch and release
    run_cmd(0, 1, 0, 1, 1, 1, 1, 1, 1, 0);
    run_cmd(1, 2, 0, 1, 1, 2, 1, 2, 1, 0);
    run_cmd(0, 0, 0, 0, 0, 2, 2, 1, 2, 0);

    // R7 zero count, with and without lock
    run_cmd(0, 0, 0, 1, 1, 0, 1, 1, 1, 0);
    run_cmd(1, 0, 0, 0, 0, 0, 1, 1, 1, 0);

    // R12 write stall
    run_cmd(0, 0, 0, 0, 0, 2, 1, 1, 1, 5);
    run_cmd(0, 0, 0, 1, 0, 3, 1, 2, 2, 3);

    // R8 wait-for-ready
    rb_settle(1'b1);
    run_wait(3, 1, -1, 1, 1'b0, "R8 already ready");
    rb_settle(1'b0);
    run_wait(2, 1, 10, 13, 1'b0, "R8 synced rise");
    chk(!err_sticky, "R11 sticky clear before timeout", err_sticky, 0);

    // R10 ready and timeout in the same cycle: ready wins
    rb_settle(1'b0);
    run_wait(2, 1, 4093, 4096, 1'b0, "R10 race");
    chk(!err_sticky, "R10 no sticky on race", err_sticky, 0);

    // R9 timeout one cycle after the race point
    rb_settle(1'b0);
    run_wait(2, 1, 4094, 4096, 1'b1, "R9 timeout");
    chk(err_sticky, "R11 sticky set", err_sticky, 1);

    // R9 zero field
    rb_settle(1'b0);
    run_wait(2, 0, -1, 1, 1'b1, "R9 zero field");

    // R11 sticky survives successful work
    run_cmd(0, 0, 0, 0, 0, 2, 1, 1, 1, 0);
    rb_settle(1'b1);
    run_wait(2, 1, -1, 1, 1'b0, "R11 later ready");
    chk(err_sticky, "R11 sticky held", err_sticky, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule